// File: doc/BRIEF.md
# SDRAM Bank Access Command Controller

This block sits between a simple host request port and a single-data-rate SDRAM device. The host hands over one read or write at a time through a valid/ready handshake, each carrying a linear word address and, for writes, one data word. The controller splits the address into row, bank and column fields. It remembers which row is open in each of the four banks, and it emits the shortest legal command sequence for each request. A request that hits the open row needs only a column command. A request to an idle bank needs an activate first. A request to a bank with a different row open needs a precharge of that one bank, then an activate, then the column command.

Every spacing limit is a parameter counted in clock cycles. These are activate-to-column, precharge period, minimum row-active time and write recovery. Each bank enforces its own limits, so work on one bank never stalls another. A per-request close flag sets the auto-precharge bit on the column command. With that flag the bank is released without a separate precharge. Read data is captured from the data bus exactly CAS latency cycles after the device registers the read. The byte masks are unmasked only in the cycles where the device actually uses the bus. Accesses are single-word (burst length one); initialization, refresh and mode programming are left to other logic.

Top module: `sdram_bank_ctrl`

## Requirements
- R1: Commands on {cs_n, ras_n, cas_n, we_n} use NOP=0111, ACTIVE=0011, READ=0101, WRITE=0100, PRECHARGE=0010. Out of reset, and in every cycle without a command, the outputs carry NOP, all byte masks are high, the write bus is not driven, rd_valid is low and req_ready is high.
- R2: req_addr is split as {row[ROW_W-1:0], bank[1:0], col[COL_W-1:0]} from the top bit down. ACTIVE drives that bank on sd_ba and the row on sd_a. READ/WRITE drive the bank on sd_ba and the column on sd_a[COL_W-1:0].
- R3: A request to a bank with no open row issues ACTIVE as soon as that bank's precharge period has elapsed. The column command follows exactly T_RCD cycles after the ACTIVE.
- R4: A request to the row already open in its bank issues no ACTIVE or PRECHARGE. Successive hits, offered back to back, issue one column command per cycle.
- R5: A request that finds another row open in its bank issues PRECHARGE to that bank with sd_a[10]=0. ACTIVE follows exactly T_RP cycles later.
- R6: PRECHARGE to a bank is issued at the later of T_RAS cycles after its ACTIVE and T_WR cycles after its last WRITE, and not earlier.
- R7: For a READ shown on the command outputs in cycle c, sd_dq_in is sampled at the end of cycle c+CL, and rd_data is presented with a one-cycle rd_valid pulse in cycle c+CL+1.
- R8: sd_dqm is all zero in the cycle of a WRITE, together with sd_dq_oe and the write word on sd_dq_out. It is all zero in cycle c+CL-2 for a READ in cycle c. It is all ones in every other cycle. sd_dq_oe is high only in WRITE cycles.
- R9: With req_close set, the column command carries sd_a[10]=1 and is issued no earlier than T_RAS cycles after the bank's ACTIVE. The bank is then treated as closed: the next access to it issues ACTIVE with no PRECHARGE, T_RP cycles after a closing READ or T_WR+T_RP cycles after a closing WRITE. With req_close clear, sd_a[10]=0 and the row stays open.
- R10: Each of the four banks keeps its own open row. Hits to different open banks, offered back to back, issue consecutive column commands with no ACTIVE or PRECHARGE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller accepts the request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_close | input | 1 | Close the row after this access |
| req_addr | input | ROW_W+2+COL_W | Linear word address {row, bank, col} |
| req_wdata | input | DATA_W | Write word |
| rd_valid | output | 1 | Read word valid pulse |
| rd_data | output | DATA_W | Read word |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_a | output | ROW_W | Multiplexed row/column address, bit 10 auto-precharge |
| sd_dqm | output | DATA_W/8 | Byte masks, active high |
| sd_dq_out | output | DATA_W | Write data to the device |
| sd_dq_oe | output | 1 | Drive enable for the data bus |
| sd_dq_in | input | DATA_W | Read data from the device |

## Verification
A corrupted open-row entry shows up on the command pins within the next request to that bank. A false hit issues a column command with no preceding ACTIVE. A false miss inserts a PRECHARGE/ACTIVE pair that a hit should never carry. A wrong spacing counter moves a PRECHARGE, ACTIVE or column command by whole cycles, which the exact cycle distances measured between commands expose on the first access through that path. A misaligned capture pipeline either returns the idle bus pattern instead of the read word, or moves the rd_valid pulse and the DQM unmask window off CL+1 and CL-2 cycles after the READ.

// File: rtl/sdram_ctrl_pkg.sv
package sdram_ctrl_pkg;
    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_LMR   = 4'b0000,
        CMD_REF   = 4'b0001,
        CMD_PRE   = 4'b0010,
        CMD_ACT   = 4'b0011,
        CMD_WR    = 4'b0100,
        CMD_RD    = 4'b0101,
        CMD_BST   = 4'b0110,
        CMD_NOP   = 4'b0111
    } sd_cmd_e;

    localparam int AP_BIT = 10;
endpackage

// File: rtl/sdram_bank_state.sv
module sdram_bank_state #(
    parameter int ROW_W = 13,
    parameter int T_RCD = 3,
    parameter int T_RP  = 3,
    parameter int T_RAS = 6,
    parameter int T_WR  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_i,
    input  logic             pre_i,
    input  logic             col_i,
    input  logic             wr_i,
    input  logic             ap_i,
    input  logic [ROW_W-1:0] row_i,
    output logic             open_o,
    output logic [ROW_W-1:0] row_o,
    output logic             col_ok_o,
    output logic             pre_ok_o,
    output logic             act_ok_o
);
    localparam int CNT_W = $clog2(T_WR + T_RP + T_RAS + T_RCD + 1) + 1;

    typedef struct packed {
        logic             open;
        logic [ROW_W-1:0] row;
        logic [CNT_W-1:0] rcd;
        logic [CNT_W-1:0] ras;
        logic [CNT_W-1:0] wrc;
        logic [CNT_W-1:0] rp;
    } bank_t;

    bank_t st_d, st_q;

    function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] v);
        return (v == '0) ? v : v - 1'b1;
    endfunction

    always_comb begin
        st_d     = st_q;
        st_d.rcd = step(st_q.rcd);
        st_d.ras = step(st_q.ras);
        st_d.wrc = step(st_q.wrc);
        st_d.rp  = step(st_q.rp);
        if (act_i) begin
            st_d.open = 1'b1;
            st_d.row  = row_i;
            st_d.rcd  = CNT_W'(T_RCD - 1);
            st_d.ras  = CNT_W'(T_RAS - 1);
        end
        if (pre_i) begin
            st_d.open = 1'b0;
            st_d.rp   = CNT_W'(T_RP - 1);
        end
        if (col_i) begin
            if (wr_i) st_d.wrc = CNT_W'(T_WR - 1);
            if (ap_i) begin
                st_d.open = 1'b0;
                st_d.rp   = wr_i ? CNT_W'(T_WR + T_RP - 1) : CNT_W'(T_RP - 1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign open_o   = st_q.open;
    assign row_o    = st_q.row;
    assign col_ok_o = (st_q.rcd == '0);
    assign pre_ok_o = (st_q.ras == '0) && (st_q.wrc == '0);
    assign act_ok_o = (st_q.rp == '0);
endmodule

// File: rtl/sdram_rd_align.sv
module sdram_rd_align #(
    parameter int CL     = 2,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_issue_i,
    input  logic [DATA_W-1:0] dq_i,
    output logic              unmask_o,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o
);
    typedef struct packed {
        logic [CL:0]       pipe;
        logic              valid;
        logic [DATA_W-1:0] data;
    } algn_t;

    algn_t al_d, al_q;

    always_comb begin
        al_d       = al_q;
        al_d.pipe  = {al_q.pipe[CL-1:0], rd_issue_i};
        al_d.valid = al_q.pipe[CL];
        if (al_q.pipe[CL]) al_d.data = dq_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) al_q <= '0;
        else        al_q <= al_d;
    end

    // mask is registered by the device two cycles ahead of the data
    generate
        if (CL == 2) begin : g_cl2
            assign unmask_o = rd_issue_i;
        end else begin : g_cl3
            assign unmask_o = al_q.pipe[CL-3];
        end
    endgenerate

    assign valid_o = al_q.valid;
    assign data_o  = al_q.data;
endmodule

// File: rtl/sdram_bank_ctrl.sv
module sdram_bank_ctrl
    import sdram_ctrl_pkg::*;
#(
    parameter int ROW_W  = 13,
    parameter int COL_W  = 9,
    parameter int DATA_W = 16,
    parameter int CL     = 2,
    parameter int T_RCD  = 3,
    parameter int T_RP   = 3,
    parameter int T_RAS  = 6,
    parameter int T_WR   = 2,
    localparam int BANK_W = 2,
    localparam int NB     = 1 << BANK_W,
    localparam int ADDR_W = ROW_W + BANK_W + COL_W,
    localparam int DQM_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_close,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ROW_W-1:0]  sd_a,
    output logic [DQM_W-1:0]  sd_dqm,
    output logic [DATA_W-1:0] sd_dq_out,
    output logic              sd_dq_oe,
    input  logic [DATA_W-1:0] sd_dq_in
);
    typedef struct packed {
        logic              pend;
        logic              wr;
        logic              close;
        logic [ROW_W-1:0]  row;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
        logic [DATA_W-1:0] wdata;
        sd_cmd_e           cmd;
        logic [BANK_W-1:0] ba;
        logic [ROW_W-1:0]  a;
        logic [DATA_W-1:0] dq;
        logic              oe;
        logic              dqm;
    } ctrl_t;

    ctrl_t ct_d, ct_q;

    logic [NB-1:0]    open_v, col_ok_v, pre_ok_v, act_ok_v;
    logic [ROW_W-1:0] row_v [NB];
    logic             hit, do_col, do_pre, do_act, rd_unmask;

    generate
        for (genvar gi = 0; gi < NB; gi++) begin : g_bank
            sdram_bank_state #(
                .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_WR(T_WR)
            ) u_bank (
                .clk     (clk),
                .rst_n   (rst_n),
                .act_i   (do_act && (ct_q.bank == BANK_W'(gi))),
                .pre_i   (do_pre && (ct_q.bank == BANK_W'(gi))),
                .col_i   (do_col && (ct_q.bank == BANK_W'(gi))),
                .wr_i    (ct_q.wr),
                .ap_i    (ct_q.close),
                .row_i   (ct_q.row),
                .open_o  (open_v[gi]),
                .row_o   (row_v[gi]),
                .col_ok_o(col_ok_v[gi]),
                .pre_ok_o(pre_ok_v[gi]),
                .act_ok_o(act_ok_v[gi])
            );
        end
    endgenerate

    sdram_rd_align #(.CL(CL), .DATA_W(DATA_W)) u_align (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_issue_i(do_col && !ct_q.wr),
        .dq_i      (sd_dq_in),
        .unmask_o  (rd_unmask),
        .valid_o   (rd_valid),
        .data_o    (rd_data)
    );

    always_comb begin
        hit    = open_v[ct_q.bank] && (row_v[ct_q.bank] == ct_q.row);
        do_col = ct_q.pend && hit && col_ok_v[ct_q.bank]
                 && (!ct_q.close || pre_ok_v[ct_q.bank]);
        do_pre = ct_q.pend && open_v[ct_q.bank] && !hit && pre_ok_v[ct_q.bank];
        do_act = ct_q.pend && !open_v[ct_q.bank] && act_ok_v[ct_q.bank];
        req_ready = !ct_q.pend || do_col;

        ct_d     = ct_q;
        ct_d.cmd = CMD_NOP;
        ct_d.ba  = ct_q.bank;
        ct_d.a   = '0;
        ct_d.oe  = 1'b0;
        ct_d.dq  = '0;
        if (do_act) begin
            ct_d.cmd = CMD_ACT;
            ct_d.a   = ct_q.row;
        end else if (do_pre) begin
            ct_d.cmd = CMD_PRE;          // bit 10 low: this bank only
        end else if (do_col) begin
            ct_d.cmd            = ct_q.wr ? CMD_WR : CMD_RD;
            ct_d.a[COL_W-1:0]   = ct_q.col;
            ct_d.a[AP_BIT]      = ct_q.close;
            ct_d.oe             = ct_q.wr;
            ct_d.dq             = ct_q.wr ? ct_q.wdata : '0;
            ct_d.pend           = 1'b0;
        end
        ct_d.dqm = !((do_col && ct_q.wr) || rd_unmask);

        if (req_valid && req_ready) begin
            ct_d.pend  = 1'b1;
            ct_d.wr    = req_write;
            ct_d.close = req_close;
            ct_d.row   = req_addr[ADDR_W-1 -: ROW_W];
            ct_d.bank  = req_addr[COL_W +: BANK_W];
            ct_d.col   = req_addr[COL_W-1:0];
            ct_d.wdata = req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ct_q     <= '0;
            ct_q.cmd <= CMD_NOP;
            ct_q.dqm <= 1'b1;
        end else begin
            ct_q <= ct_d;
        end
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = ct_q.cmd;
    assign sd_ba     = ct_q.ba;
    assign sd_a      = ct_q.a;
    assign sd_dqm    = {DQM_W{ct_q.dqm}};
    assign sd_dq_out = ct_q.dq;
    assign sd_dq_oe  = ct_q.oe;
endmodule

// File: rtl/sdram_bank_ctrl_chk.sv
module sdram_bank_ctrl_chk #(
    parameter int ROW_W  = 13,
    parameter int DATA_W = 16,
    parameter int CL     = 2,
    parameter int T_RCD  = 3,
    parameter int T_RP   = 3,
    parameter int T_RAS  = 6,
    parameter int T_WR   = 2,
    localparam int DQM_W = DATA_W / 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             ras_n,
    input logic             cas_n,
    input logic             we_n,
    input logic [1:0]       ba,
    input logic [ROW_W-1:0] a,
    input logic [DQM_W-1:0] dqm,
    input logic             dq_oe,
    input logic             rd_valid
);
    localparam int CW = $clog2(T_WR + T_RP + T_RAS + T_RCD + 2) + 1;

    logic [3:0] cmd;
    logic is_act, is_pre, is_rd, is_wr;
    assign cmd    = {cs_n, ras_n, cas_n, we_n};
    assign is_act = (cmd == 4'b0011);
    assign is_pre = (cmd == 4'b0010);
    assign is_rd  = (cmd == 4'b0101);
    assign is_wr  = (cmd == 4'b0100);

    generate
        for (genvar gb = 0; gb < 4; gb++) begin : g_b
            logic          sel, opn;
            logic [CW-1:0] s_act, s_pre, s_wr, need;
            assign sel = (ba == 2'(gb));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    opn <= 1'b0; s_act <= '1; s_pre <= '1; s_wr <= '1; need <= '0;
                end else begin
                    if (s_act != '1) s_act <= s_act + 1'b1;
                    if (s_pre != '1) s_pre <= s_pre + 1'b1;
                    if (s_wr  != '1) s_wr  <= s_wr  + 1'b1;
                    if (is_act && sel) begin opn <= 1'b1; s_act <= CW'(1); end
                    if (is_pre && (sel || a[10])) begin
                        opn <= 1'b0; s_pre <= CW'(1); need <= CW'(T_RP);
                    end
                    if ((is_rd || is_wr) && sel) begin
                        if (is_wr) s_wr <= CW'(1);
                        if (a[10]) begin
                            opn <= 1'b0; s_pre <= CW'(1);
                            need <= is_wr ? CW'(T_WR + T_RP) : CW'(T_RP);
                        end
                    end
                end
            end

            assert_rcd_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (is_rd || is_wr) && sel |-> s_act >= CW'(T_RCD));
            assert_col_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (is_rd || is_wr) && sel |-> opn);
            assert_ras_wr_R6: assert property (@(posedge clk) disable iff (!rst_n)
                is_pre && sel && opn |-> (s_act >= CW'(T_RAS)) && (s_wr >= CW'(T_WR)));
            assert_rp_R5: assert property (@(posedge clk) disable iff (!rst_n)
                is_act && sel |-> s_pre >= need);
            assert_act_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
                is_act && sel |-> !opn);
            assert_close_ras_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (is_rd || is_wr) && sel && a[10] |-> s_act >= CW'(T_RAS));
        end
    endgenerate

    assert_rd_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(is_rd, CL + 1));
    assert_wr_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
        is_wr |-> dq_oe && (dqm == '0));
    assert_oe_only_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !is_wr |-> !dq_oe);
    assert_pre_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> !a[10]);
endmodule

bind sdram_bank_ctrl sdram_bank_ctrl_chk #(
    .ROW_W(ROW_W), .DATA_W(DATA_W), .CL(CL),
    .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_WR(T_WR)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .cs_n(sd_cs_n), .ras_n(sd_ras_n), .cas_n(sd_cas_n), .we_n(sd_we_n),
    .ba(sd_ba), .a(sd_a), .dqm(sd_dqm), .dq_oe(sd_dq_oe), .rd_valid(rd_valid)
);

// File: tb/sdram_bank_ctrl_test.sv
module sdram_bank_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int ROW_W = 13, COL_W = 9, DATA_W = 16, CL = 3;
    localparam int T_RCD = 3, T_RP = 3, T_RAS = 6, T_WR = 4;
    localparam int ADDR_W = ROW_W + 2 + COL_W;
    localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                           C_WR = 4'b0100, C_PRE = 4'b0010;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, req_close = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic [DATA_W-1:0] sd_dq_in = 16'hDEAD;
    logic req_ready, rd_valid, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
    logic [DATA_W-1:0] rd_data, sd_dq_out;
    logic [1:0] sd_ba, sd_dqm;
    logic [ROW_W-1:0] sd_a;

    int vectors = 0, miscompares = 0;

    sdram_bank_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .CL(CL),
        .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_WR(T_WR)) uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] mdat(input logic [1:0] b, input logic [8:0] c);
        return 16'h5A00 ^ {5'd0, b, c};
    endfunction

    // command log and device model, sampled at the falling edge
    int cyc = 0, lcnt = 0, rv_cnt = 0, rv_cyc = 0;
    logic [3:0]  lcmd [64];
    int          lcyc [64];
    logic [1:0]  lba  [64];
    logic [12:0] la   [64];
    logic [15:0] ldq  [64];
    logic        loe  [64];
    logic [1:0]  ldqm [64];
    logic [1:0]  dqm_h [64];
    logic        oe_h  [64];
    logic [15:0] rv_data;
    logic [3:0]  mv = '0;
    logic [15:0] md [4];

    always @(negedge clk) begin
        logic [3:0] c;
        cyc = cyc + 1;
        c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        dqm_h[cyc % 64] = sd_dqm;
        oe_h[cyc % 64]  = sd_dq_oe;
        if (rst_n && c != C_NOP) begin
            lcmd[lcnt % 64] = c; lcyc[lcnt % 64] = cyc; lba[lcnt % 64] = sd_ba;
            la[lcnt % 64] = sd_a; ldq[lcnt % 64] = sd_dq_out;
            loe[lcnt % 64] = sd_dq_oe; ldqm[lcnt % 64] = sd_dqm;
            lcnt = lcnt + 1;
        end
        if (rst_n && rd_valid) begin rv_cnt = rv_cnt + 1; rv_cyc = cyc; rv_data = rd_data; end
        for (int k = 3; k > 0; k--) md[k] = md[k-1];
        md[0] = mdat(sd_ba, sd_a[8:0]);
        mv = {mv[2:0], (c == C_RD)};
        sd_dq_in = mv[CL] ? md[CL] : 16'hDEAD;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] mk(input int row, input int bank, input int col);
        return {ROW_W'(row), 2'(bank), COL_W'(col)};
    endfunction

    task automatic push(input bit w, input logic [ADDR_W-1:0] ad,
                        input logic [15:0] wd, input bit cl);
        bit ok;
        req_valid = 1'b1; req_write = w; req_addr = ad; req_wdata = wd; req_close = cl;
        do begin
            ok = req_ready;
            @(negedge clk);
        end while (!ok);
    endtask

    task automatic release_req();
        req_valid = 1'b0; req_write = 1'b0; req_close = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R1 reset cmd",
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_NOP);
        chk(sd_dqm == 2'b11, "R1 reset dqm", sd_dqm, 3);
        chk(!sd_dq_oe && !rd_valid, "R1 reset oe/valid", {sd_dq_oe, rd_valid}, 0);
        chk(req_ready, "R1 reset ready", req_ready, 1);
    endtask

    task automatic t_idle();
        int b = lcnt;
        idle(12);
        chk(lcnt == b, "R1 idle issues only NOP", lcnt - b, 0);
        chk(sd_dqm == 2'b11 && !sd_dq_oe, "R8 idle masks", {sd_dqm, sd_dq_oe}, 6);
    endtask

    task automatic t_read_closed();
        int b = lcnt, r0 = rv_cnt, rc;
        push(0, mk(5, 0, 7), 0, 0); release_req(); idle(20);
        chk(lcmd[b] == C_ACT && lba[b] == 0 && la[b] == 5, "R2 ACT bank/row",
            {lcmd[b], lba[b], la[b]}, {C_ACT, 2'd0, 13'd5});
        chk(lcmd[b+1] == C_RD && la[b+1][8:0] == 7 && !la[b+1][10], "R2 READ col",
            {lcmd[b+1], la[b+1]}, {C_RD, 13'd7});
        chk(lcyc[b+1] - lcyc[b] == T_RCD, "R3 ACT to READ", lcyc[b+1] - lcyc[b], T_RCD);
        rc = lcyc[b+1];
        chk(rv_cnt == r0 + 1, "R7 one rd_valid pulse", rv_cnt - r0, 1);
        chk(rv_cyc - rc == CL + 1, "R7 read latency", rv_cyc - rc, CL + 1);
        chk(rv_data == mdat(0, 7), "R7 read data", rv_data, mdat(0, 7));
        chk(dqm_h[(rc + CL - 2) % 64] == 2'b00, "R8 read unmask", dqm_h[(rc + CL - 2) % 64], 0);
        chk(dqm_h[(rc + CL - 1) % 64] == 2'b11, "R8 read remask", dqm_h[(rc + CL - 1) % 64], 3);
    endtask

    task automatic t_hits();
        int b = lcnt;
        push(0, mk(5, 0, 8), 0, 0); push(0, mk(5, 0, 9), 0, 0); release_req(); idle(12);
        chk(lcnt - b == 2, "R4 hits add no ACT/PRE", lcnt - b, 2);
        chk(lcmd[b] == C_RD && lcmd[b+1] == C_RD, "R4 hit commands",
            {lcmd[b], lcmd[b+1]}, {C_RD, C_RD});
        chk(lcyc[b+1] - lcyc[b] == 1, "R4 back-to-back", lcyc[b+1] - lcyc[b], 1);
    endtask

    task automatic t_miss();
        int b = lcnt;
        push(0, mk(9, 0, 1), 0, 0); release_req(); idle(16);
        chk(lcmd[b] == C_PRE && lba[b] == 0 && !la[b][10], "R5 single-bank PRE",
            {lcmd[b], lba[b], la[b][10]}, {C_PRE, 2'd0, 1'b0});
        chk(lcmd[b+1] == C_ACT && la[b+1] == 9, "R5 ACT new row", la[b+1], 9);
        chk(lcyc[b+1] - lcyc[b] == T_RP, "R5 PRE to ACT", lcyc[b+1] - lcyc[b], T_RP);
        chk(lcmd[b+2] == C_RD && lcyc[b+2] - lcyc[b+1] == T_RCD, "R3 miss ACT to READ",
            lcyc[b+2] - lcyc[b+1], T_RCD);
    endtask

    task automatic t_ras();
        int b = lcnt;
        push(0, mk(1, 1, 3), 0, 0); push(0, mk(2, 1, 3), 0, 0); release_req(); idle(25);
        chk(lcmd[b+2] == C_PRE && lba[b+2] == 1, "R6 PRE after tRAS", lcmd[b+2], C_PRE);
        chk(lcyc[b+2] - lcyc[b] == T_RAS, "R6 ACT to PRE", lcyc[b+2] - lcyc[b], T_RAS);
        chk(lcmd[b+3] == C_ACT && la[b+3] == 2, "R5 reopen row 2", la[b+3], 2);
    endtask

    task automatic t_write();
        int b = lcnt;
        push(1, mk(3, 2, 4), 16'hC3A5, 0); push(1, mk(4, 2, 5), 16'h0F1E, 0);
        release_req(); idle(25);
        chk(lcmd[b+1] == C_WR && la[b+1][8:0] == 4 && lba[b+1] == 2, "R2 WRITE col",
            {lcmd[b+1], la[b+1]}, {C_WR, 13'd4});
        chk(ldq[b+1] == 16'hC3A5 && loe[b+1] && ldqm[b+1] == 0, "R8 write bus",
            {ldq[b+1], loe[b+1], ldqm[b+1]}, {16'hC3A5, 1'b1, 2'b00});
        chk(!oe_h[(lcyc[b+1] + 1) % 64] && dqm_h[(lcyc[b+1] + 1) % 64] == 2'b11,
            "R8 bus released after write", oe_h[(lcyc[b+1] + 1) % 64], 0);
        chk(lcmd[b+2] == C_PRE && lcyc[b+2] - lcyc[b+1] == T_WR, "R6 write recovery",
            lcyc[b+2] - lcyc[b+1], T_WR);
        chk(lcmd[b+4] == C_WR && ldq[b+4] == 16'h0F1E, "R8 second write data",
            ldq[b+4], 16'h0F1E);
    endtask

    task automatic t_close_read();
        int b = lcnt;
        push(0, mk(7, 3, 2), 0, 1); push(0, mk(8, 3, 2), 0, 0); release_req(); idle(25);
        chk(lcmd[b+1] == C_RD && la[b+1][10], "R9 READ auto-precharge", la[b+1][10], 1);
        chk(lcyc[b+1] - lcyc[b] == T_RAS, "R9 close waits tRAS", lcyc[b+1] - lcyc[b], T_RAS);
        chk(lcmd[b+2] == C_ACT && lcyc[b+2] - lcyc[b+1] == T_RP, "R9 ACT after read close",
            {lcmd[b+2], 32'(lcyc[b+2] - lcyc[b+1])}, {C_ACT, 32'(T_RP)});
        chk(lcmd[b+3] == C_RD && !la[b+3][10], "R9 open-page READ", la[b+3][10], 0);
    endtask

    task automatic t_close_write();
        int b = lcnt;
        push(1, mk(8, 3, 6), 16'h1234, 1); push(0, mk(8, 3, 6), 0, 0); release_req(); idle(25);
        chk(lcmd[b] == C_WR && la[b][10], "R9 WRITE auto-precharge", la[b][10], 1);
        chk(lcmd[b+1] == C_ACT && lcyc[b+1] - lcyc[b] == T_WR + T_RP, "R9 ACT after write close",
            {lcmd[b+1], 32'(lcyc[b+1] - lcyc[b])}, {C_ACT, 32'(T_WR + T_RP)});
    endtask

    task automatic t_banks();
        int b = lcnt;
        push(0, mk(2, 1, 11), 0, 0); push(0, mk(4, 2, 12), 0, 0); push(0, mk(9, 0, 13), 0, 0);
        release_req(); idle(12);
        chk(lcnt - b == 3, "R10 no ACT/PRE across banks", lcnt - b, 3);
        chk(lcmd[b] == C_RD && lcmd[b+2] == C_RD && lcyc[b+2] - lcyc[b] == 2,
            "R10 consecutive reads", lcyc[b+2] - lcyc[b], 2);
        chk(lba[b] == 1 && lba[b+1] == 2 && lba[b+2] == 0, "R10 bank order",
            {lba[b], lba[b+1], lba[b+2]}, {2'd1, 2'd2, 2'd0});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        idle(2);
        t_idle();
        t_read_closed();
        t_hits();
        t_miss();
        t_ras();
        t_write();
        t_close_read();
        t_close_write();
        t_banks();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule